// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Multiplier

This block multiplies a stream of activation rows by a square weight matrix held inside an N×N grid of multiply-accumulate cells. The caller first shifts the weight matrix in through the top edge, one row per cycle over N cycles. The weights then stay fixed in the cells while activation rows arrive on a separate valid-qualified stream, one row of N signed 8-bit values per cycle. Inside the block, element k of a row is delayed k cycles before it enters array row k. Each cell multiplies the passing activation by its stored weight, adds the partial sum from the cell above, and hands the activation to its right-hand neighbour.

Finished dot products leave the bottom edge one column per cycle. A delay line de-skews them, so each input row comes back as one aligned output row of N signed 32-bit results together with a valid flag. Rows can arrive on every cycle with no gap, so an 8-row tile is accepted in 8 cycles and produces 8 consecutive result rows. Operands whose size is not a multiple of N must be zero-padded by the caller.

Top module: `ws_matmul`

## Requirements
- R1: While `w_load` is high, the row on `w_row` enters the top row of the grid and each stored row moves down one row. To load a weight matrix W, the caller presents W row N-1 first and W row 0 last, over N cycles. Element W[k][j] travels in `w_row[j*8 +: 8]`.
- R2: While `w_load` is low, the stored weights do not change and `w_row` is ignored, even while activations are streaming.
- R3: For an accepted activation row a, where a[k] is `a_row[k*8 +: 8]`, the result field `out_row[j*32 +: 32]` equals the sum over k of a[k]·W[k][j]. All values are two's-complement.
- R4: A row accepted on a rising edge (when `a_valid` is high) appears on the outputs, with `out_valid` high, after the 2N-2nd rising edge that follows. Rows come out in order of acceptance. Back-to-back input rows give back-to-back output rows.
- R5: When `a_valid` is low, `a_row` is ignored and no result row is produced for that cycle.
- R6: Whenever `out_valid` is low, `out_row` is all zeros.
- R7: `rst_n` is a synchronous, active-low reset. It clears every row in flight. `out_valid` is low and `out_row` is zero after any edge that samples reset, and rows accepted before the reset never appear. Stored weights are not cleared.
- R8: Full-range operands are exact, including -128·-128 products summed over all N rows. For N=4 that sum is 65536.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| w_load | input | 1 | Shift `w_row` into the top of the grid this cycle |
| w_row | input | N*8 | One weight row, column j in byte j |
| a_valid | input | 1 | `a_row` carries an activation row this cycle |
| a_row | input | N*8 | One activation row, element k in byte k |
| out_valid | output | 1 | `out_row` carries a finished result row |
| out_row | output | N*32 | Result row, column j in word j |

## Verification
On every cycle, the assertions check that an idle output is zero and that no result row leaves without a matching accepted row. They also bound the number of rows in flight by the pipeline depth and check that an edge sampling reset leaves the outputs idle and zero. The bench scenarios are the only place that shows the arithmetic itself: the load order of the weight rows, exact signed sums at full range, and the latency of each row. They also show that weights hold while `w_row` toggles, and that rows sent before a mid-stream reset are discarded.

// File: rtl/ws_matmul.sv
module ws_matmul #(
  parameter int N  = 4,
  parameter int DW = 8,
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            w_load,
  input  logic [N*DW-1:0] w_row,
  input  logic            a_valid,
  input  logic [N*DW-1:0] a_row,
  output logic            out_valid,
  output logic [N*AW-1:0] out_row
);
  localparam int VL = 2*N-1;
  localparam int PW = 2*DW;

  logic signed [DW-1:0] w_q    [N][N];
  logic signed [DW-1:0] a_q    [N][N];
  logic signed [AW-1:0] p_q    [N][N];
  logic signed [DW-1:0] a_edge [N];
  logic [VL-1:0]        v_q;

  genvar r, c;

  for (r = 0; r < N; r++) begin : g_skew
    logic signed [DW-1:0] a_in;
    assign a_in = a_valid ? a_row[r*DW +: DW] : '0;
    if (r == 0) begin : g_direct
      assign a_edge[r] = a_in;
    end else begin : g_delay
      logic signed [DW-1:0] sk [r];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < r; i++) sk[i] <= '0;
        end else begin
          sk[0] <= a_in;
          for (int i = 1; i < r; i++) sk[i] <= sk[i-1];
        end
      end
      assign a_edge[r] = sk[r-1];
    end
  end

  for (r = 0; r < N; r++) begin : g_row
    for (c = 0; c < N; c++) begin : g_col
      logic signed [DW-1:0] a_in;
      logic signed [AW-1:0] s_in;
      logic signed [PW-1:0] prod;

      if (c == 0) begin : g_left
        assign a_in = a_edge[r];
      end else begin : g_inner
        assign a_in = a_q[r][c-1];
      end

      if (r == 0) begin : g_top
        assign s_in = '0;
      end else begin : g_below
        assign s_in = p_q[r-1][c];
      end

      assign prod = a_in * w_q[r][c];

      always_ff @(posedge clk) begin
        if (w_load) w_q[r][c] <= (r == 0) ? w_row[c*DW +: DW] : w_q[r-1][c];
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          a_q[r][c] <= '0;
          p_q[r][c] <= '0;
        end else begin
          a_q[r][c] <= a_in;
          p_q[r][c] <= s_in + {{(AW-PW){prod[PW-1]}}, prod};
        end
      end
    end
  end

  for (c = 0; c < N; c++) begin : g_dsk
    if (c == N-1) begin : g_last
      assign out_row[c*AW +: AW] = p_q[N-1][c];
    end else begin : g_line
      logic signed [AW-1:0] dl [N-1-c];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < N-1-c; i++) dl[i] <= '0;
        end else begin
          dl[0] <= p_q[N-1][c];
          for (int i = 1; i < N-1-c; i++) dl[i] <= dl[i-1];
        end
      end
      assign out_row[c*AW +: AW] = dl[N-2-c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= {v_q[VL-2:0], a_valid};
  end

  assign out_valid = v_q[VL-1];
endmodule

// File: rtl/ws_matmul_chk.sv
module ws_matmul_chk #(
  parameter int N  = 4,
  parameter int AW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            a_valid,
  input logic            out_valid,
  input logic [N*AW-1:0] out_row
);
  localparam int CW   = $clog2(2*N) + 2;
  localparam int DMAX = 2*N-1;

  logic [CW-1:0] pend;
  logic          rst_lo;

  always_ff @(posedge clk) begin
    rst_lo <= !rst_n;
    if (!rst_n) pend <= '0;
    else        pend <= pend + CW'(a_valid) - CW'(out_valid);
  end

  always_ff @(posedge clk) begin
    if (rst_lo) begin
      p_rst_clear_r7: assert (!out_valid && out_row == '0)
        else $error("outputs not idle after reset");
    end
  end

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_row == '0);

  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> pend != '0);

  p_inflight_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= CW'(DMAX));
endmodule

bind ws_matmul ws_matmul_chk #(.N(N), .AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .a_valid(a_valid),
  .out_valid(out_valid), .out_row(out_row)
);

// File: tb/test_ws_matmul.sv
module test_ws_matmul;
  localparam int CLK_P = 10;
  localparam int N     = 4;
  localparam int DW    = 8;
  localparam int AW    = 32;
  localparam int LAT   = 2*N-1;
  localparam int TAB_N = 8;

  localparam logic [N*DW-1:0] A_TAB [TAB_N] = '{
    32'h01_02_03_04, 32'hFF_FE_FD_FC, 32'h80_7F_00_01, 32'h00_00_00_00,
    32'h7F_7F_7F_7F, 32'h80_80_80_80, 32'h10_F0_22_DE, 32'h05_FB_09_F7
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic w_load = 1'b0, a_valid = 1'b0;
  logic [N*DW-1:0] w_row = '0, a_row = '0;
  logic out_valid;
  logic [N*AW-1:0] out_row;

  ws_matmul #(.N(N), .DW(DW), .AW(AW)) i_ws_matmul (
    .clk(clk), .rst_n(rst_n), .w_load(w_load), .w_row(w_row),
    .a_valid(a_valid), .a_row(a_row), .out_valid(out_valid), .out_row(out_row)
  );

  always #(CLK_P/2) clk = ~clk;

  int wm [N][N];
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic done = 1'b0;
  logic [N*AW-1:0] exp_q [$];
  int              iss_q [$];
  string           tag_q [$];

  function automatic logic [N*AW-1:0] ref_row(input logic [N*DW-1:0] a);
    logic [N*AW-1:0] res = '0;
    for (int j = 0; j < N; j++) begin
      int acc = 0;
      for (int k = 0; k < N; k++) acc += $signed(a[k*DW +: DW]) * wm[k][j];
      res[j*AW +: AW] = acc;
    end
    return res;
  endfunction

  task automatic chk_vec(input string req, input logic [N*AW-1:0] act, input logic [N*AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic monitor();
    if (out_valid) begin
      if (exp_q.size() == 0) begin
        chk_int("R5 R7 unexpected out_valid", 1, 0);
      end else begin
        logic [N*AW-1:0] e = exp_q.pop_front();
        int    i = iss_q.pop_front();
        string t = tag_q.pop_front();
        chk_vec({t, " result"}, out_row, e);
        chk_int("R4 latency", cyc - i, LAT);
      end
    end else begin
      chk_vec("R6 idle output zero", out_row, '0);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_P/4);
    cyc++;
    if (rst_n) monitor();
  endtask

  task automatic send(input logic [N*DW-1:0] a, input string t);
    a_valid = 1'b1;
    a_row   = a;
    exp_q.push_back(ref_row(a));
    iss_q.push_back(cyc);
    tag_q.push_back(t);
    tick();
    a_valid = 1'b0;
  endtask

  task automatic idle(input int n, input logic [N*DW-1:0] junk);
    a_valid = 1'b0;
    a_row   = junk;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic load_w();
    for (int i = 0; i < N; i++) begin
      w_load = 1'b1;
      for (int j = 0; j < N; j++) w_row[j*DW +: DW] = wm[N-1-i][j][DW-1:0];
      tick();
    end
    w_load = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P*200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R4: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) tick();
    chk_int("R7 valid low in reset", int'(out_valid), 0);
    chk_vec("R7 output zero in reset", out_row, '0);
    rst_n = 1'b1;
    tick();

    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) wm[r][c] = r*N + c - 7;
    load_w();

    for (int i = 0; i < TAB_N; i++) send(A_TAB[i], "R1 R3 tile");

    for (int i = 0; i < TAB_N; i++) begin
      w_row = {N{8'h5A ^ 8'(i*37)}};
      send(A_TAB[TAB_N-1-i], "R2 weights held");
    end
    w_row = '1;

    idle(LAT + 2, 32'hDEAD_BEEF);

    send(A_TAB[0], "R4 R5 bubble");
    idle(1, 32'h1234_5678);
    send(A_TAB[6], "R4 R5 bubble");
    idle(2, 32'h8765_4321);
    send(A_TAB[7], "R4 R5 bubble");
    idle(LAT + 2, 32'hCAFE_F00D);

    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) wm[r][c] = (c % 2 == 0) ? -128 : 127;
    load_w();
    send(32'h80_80_80_80, "R8 full range");
    send(32'h7F_7F_7F_7F, "R8 full range");
    send(32'h80_7F_80_7F, "R8 full range");
    idle(LAT + 2, '0);

    send(A_TAB[1], "R7 flushed");
    send(A_TAB[2], "R7 flushed");
    send(A_TAB[4], "R7 flushed");
    rst_n = 1'b0;
    exp_q.delete();
    iss_q.delete();
    tag_q.delete();
    tick();
    chk_int("R7 valid low after reset edge", int'(out_valid), 0);
    chk_vec("R7 output zero after reset edge", out_row, '0);
    tick();
    rst_n = 1'b1;
    idle(LAT + 2, 32'h0F0F_0F0F);

    send(32'h80_80_80_80, "R3 R8 after reset");
    idle(LAT + 2, '0);
    chk_int("R4 all rows delivered", exp_q.size(), 0);

    finish_run();
  end
endmodule